// File: doc/BRIEF.md
# Eight-Channel Word-Copy DMA Engine with Circular Addressing

This block moves words from one memory-like resource to another without processor help. It has eight channels. Each channel reads one word from a source resource, then writes that word to a destination resource. It then waits for its own programmable interval before it starts the next transfer. Software sets up each channel through a narrow register write port: two base addresses, one shared address step, a buffer length, a wait interval and a control word.

A channel runs in one of two addressing modes. In linear mode it makes exactly `length` transfers, raises a completion pulse and stops. In circular mode both offsets wrap inside a window of `length` words above their bases. The channel keeps running until software clears its run bit, and it pulses its completion line after every `length` transfers. Each resource has its own round-robin arbiter and one request/grant port. Channels that use different resources therefore proceed in the same cycle. Completion pulses are steered to one of six interrupt lines.

Top module: `dma_engine`

## Requirements
- R1: Each of the eight channels is set up through `cfg_we`/`cfg_ch`/`cfg_field`/`cfg_wdata`. The field codes are: 0 source base, 1 destination base, 2 step (used by both addresses), 3 length, 4 wait interval, 5 control. The control word is laid out as bit0 run, bit1 circular, bit2 source resource, bit3 destination resource and bits[6:4] interrupt line. Writing control with run=1 restarts the channel from offset 0. Writing it with run=0 stops the channel, and it then issues no further accesses.
- R2: In linear mode the k-th transfer (k from 0) reads source base+k*step and writes destination base+k*step. After `length` transfers the channel issues no more accesses.
- R3: In circular mode each offset advances by step, and an offset that reaches `length` or beyond has `length` subtracted. The channel keeps transferring until it is stopped.
- R4: Each resource has an independent arbiter that grants at most one channel per cycle. Channels on different resources are served in the same cycle.
- R5: After it starts, and after each write is accepted, a channel waits `interval`+1 cycles before it requests its next read. With no contention, successive accepted reads of one channel are `interval`+4 cycles apart.
- R6: When the final write of a buffer is accepted, the selected `irq` line is high for exactly one cycle, in the cycle after that write. In circular mode this happens after every `length` transfers.
- R7: Each arbiter serves requesting channels in round-robin order. It starts after the channel it last granted, and it moves its pointer only when the resource accepts the access.
- R8: A transfer is a read followed by a write of the same word. Read data is taken from `mem_rdata` in the cycle after the read is accepted. The write is requested in the cycle after that. While `mem_gnt` is low, a requesting channel holds its request and its address.
- R9: While reset is asserted, and after it, no `mem_req` and no `irq` is active until a channel is started.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_ch | input | 3 | Channel being written |
| cfg_field | input | 3 | Field code (see R1) |
| cfg_wdata | input | 16 | Field value |
| mem_req | output | NRES (2) | Access request, one bit per resource |
| mem_we | output | NRES | 1 = write, 0 = read |
| mem_addr | output | NRES x 8 | Word address per resource |
| mem_wdata | output | NRES x 16 | Write data per resource |
| mem_gnt | input | NRES | Resource accepts the access this cycle |
| mem_rdata | input | NRES x 16 | Read data, valid the cycle after an accepted read |
| irq | output | 6 | Completion pulses |

## Verification
Two accesses can be accepted in the same cycle on different resources. One channel's write can land on one port while another channel's read is accepted on the other port. The bench provokes this by starting a channel that copies inside resource 0 two cycles before a channel that copies inside resource 1, so that their read and write phases interleave. It counts the cycles in which both ports accept an access, and it requires both copied buffers to match their sources word for word. A second pairing pits three channels against one resource while that resource is stalled. When the stall is released, the order of service is judged against round-robin rotation.

// File: rtl/dma_pkg.sv
package dma_pkg;
    typedef enum logic [2:0] {
        PH_OFF  = 3'd0,
        PH_WAIT = 3'd1,
        PH_RD   = 3'd2,
        PH_CAP  = 3'd3,
        PH_WR   = 3'd4
    } phase_e;

    localparam logic [2:0] FLD_SRC  = 3'd0;
    localparam logic [2:0] FLD_DST  = 3'd1;
    localparam logic [2:0] FLD_STEP = 3'd2;
    localparam logic [2:0] FLD_LEN  = 3'd3;
    localparam logic [2:0] FLD_PER  = 3'd4;
    localparam logic [2:0] FLD_CTRL = 3'd5;
endpackage

// File: rtl/dma_rr_arb.sv
module dma_rr_arb #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req,
    input  logic         adv,
    output logic [N-1:0] win
);
    localparam int PW = (N > 1) ? $clog2(N) : 1;

    logic [PW-1:0] last_q, last_d;

    always_comb begin
        logic          found;
        logic [PW-1:0] idx;
        win    = '0;
        last_d = last_q;
        found  = 1'b0;
        for (int i = 1; i <= N; i++) begin
            idx = PW'((int'(last_q) + i) % N);
            if (!found && req[idx]) begin
                found    = 1'b1;
                win[idx] = 1'b1;
                if (adv) last_d = idx;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) last_q <= PW'(N - 1);
        else        last_q <= last_d;
    end
endmodule

// File: rtl/dma_chan.sv
module dma_chan
    import dma_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 16,
    parameter int PW = 8,
    parameter int RW = 1,
    parameter int IW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [2:0]    cfg_field,
    input  logic [DW-1:0] cfg_wdata,
    input  logic          gnt_i,
    input  logic [DW-1:0] rdata_i,
    output logic          req_o,
    output logic          we_o,
    output logic [RW-1:0] res_o,
    output logic [AW-1:0] addr_o,
    output logic [DW-1:0] wdata_o,
    output logic [RW-1:0] src_o,
    output logic          done_o,
    output logic [IW-1:0] isel_o
);
    localparam int B_RUN = 0;
    localparam int B_MOD = 1;
    localparam int B_SRC = 2;
    localparam int B_DST = 2 + RW;
    localparam int B_IRQ = 2 + 2 * RW;

    typedef struct packed {
        logic [AW-1:0] sbase;
        logic [AW-1:0] dbase;
        logic [AW-1:0] step;
        logic [AW-1:0] len;
        logic [PW-1:0] per;
        logic          circ;
        logic [RW-1:0] sres;
        logic [RW-1:0] dres;
        logic [IW-1:0] isel;
        phase_e        ph;
        logic [AW-1:0] soff;
        logic [AW-1:0] doff;
        logic [AW-1:0] cnt;
        logic [PW-1:0] tmr;
        logic [DW-1:0] data;
        logic          done;
    } chan_t;

    chan_t st_q, st_d;

    function automatic logic [AW-1:0] adv_off(input logic [AW-1:0] off,
                                              input logic [AW-1:0] stp,
                                              input logic [AW-1:0] lim,
                                              input logic          wrap);
        logic [AW:0] sum;
        sum = {1'b0, off} + {1'b0, stp};
        if (wrap && sum >= {1'b0, lim}) sum = sum - {1'b0, lim};
        return sum[AW-1:0];
    endfunction

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        case (st_q.ph)
            PH_WAIT: begin
                if (st_q.tmr == '0) st_d.ph = PH_RD;
                else                st_d.tmr = st_q.tmr - 1'b1;
            end
            PH_RD: if (gnt_i) st_d.ph = PH_CAP;
            PH_CAP: begin
                st_d.data = rdata_i;
                st_d.ph   = PH_WR;
            end
            PH_WR: if (gnt_i) begin
                st_d.soff = adv_off(st_q.soff, st_q.step, st_q.len, st_q.circ);
                st_d.doff = adv_off(st_q.doff, st_q.step, st_q.len, st_q.circ);
                st_d.tmr  = st_q.per;
                st_d.ph   = PH_WAIT;
                if (({1'b0, st_q.cnt} + 1'b1) == {1'b0, st_q.len}) begin
                    st_d.done = 1'b1;
                    st_d.cnt  = '0;
                    if (!st_q.circ) st_d.ph = PH_OFF;
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end
            default: ;
        endcase
        if (cfg_we) begin
            case (cfg_field)
                FLD_SRC:  st_d.sbase = cfg_wdata[AW-1:0];
                FLD_DST:  st_d.dbase = cfg_wdata[AW-1:0];
                FLD_STEP: st_d.step  = cfg_wdata[AW-1:0];
                FLD_LEN:  st_d.len   = cfg_wdata[AW-1:0];
                FLD_PER:  st_d.per   = cfg_wdata[PW-1:0];
                FLD_CTRL: begin
                    st_d.circ = cfg_wdata[B_MOD];
                    st_d.sres = cfg_wdata[B_SRC +: RW];
                    st_d.dres = cfg_wdata[B_DST +: RW];
                    st_d.isel = cfg_wdata[B_IRQ +: IW];
                    st_d.soff = '0;
                    st_d.doff = '0;
                    st_d.cnt  = '0;
                    st_d.tmr  = st_q.per;
                    st_d.ph   = cfg_wdata[B_RUN] ? PH_WAIT : PH_OFF;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign req_o   = (st_q.ph == PH_RD) || (st_q.ph == PH_WR);
    assign we_o    = (st_q.ph == PH_WR);
    assign res_o   = we_o ? st_q.dres : st_q.sres;
    assign addr_o  = we_o ? (st_q.dbase + st_q.doff) : (st_q.sbase + st_q.soff);
    assign wdata_o = st_q.data;
    assign src_o   = st_q.sres;
    assign done_o  = st_q.done;
    assign isel_o  = st_q.isel;
endmodule

// File: rtl/dma_engine.sv
module dma_engine #(
    parameter int NCH  = 8,
    parameter int NRES = 2,
    parameter int AW   = 8,
    parameter int DW   = 16,
    parameter int PW   = 8,
    parameter int NIRQ = 6
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cfg_we,
    input  logic [$clog2(NCH)-1:0]     cfg_ch,
    input  logic [2:0]                 cfg_field,
    input  logic [DW-1:0]              cfg_wdata,
    output logic [NRES-1:0]            mem_req,
    output logic [NRES-1:0]            mem_we,
    output logic [NRES-1:0][AW-1:0]    mem_addr,
    output logic [NRES-1:0][DW-1:0]    mem_wdata,
    input  logic [NRES-1:0]            mem_gnt,
    input  logic [NRES-1:0][DW-1:0]    mem_rdata,
    output logic [NIRQ-1:0]            irq
);
    localparam int CW = $clog2(NCH);
    localparam int RW = $clog2(NRES);
    localparam int IW = $clog2(NIRQ);

    logic [NCH-1:0]           ch_req, ch_we, ch_gnt, ch_done;
    logic [NCH-1:0][RW-1:0]   ch_res, ch_src;
    logic [NCH-1:0][AW-1:0]   ch_addr;
    logic [NCH-1:0][DW-1:0]   ch_wdata;
    logic [NCH-1:0][IW-1:0]   ch_isel;
    logic [NRES-1:0][NCH-1:0] res_req, res_win;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        dma_chan #(.AW(AW), .DW(DW), .PW(PW), .RW(RW), .IW(IW)) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .cfg_we   (cfg_we && (cfg_ch == CW'(c))),
            .cfg_field(cfg_field),
            .cfg_wdata(cfg_wdata),
            .gnt_i    (ch_gnt[c]),
            .rdata_i  (mem_rdata[ch_src[c]]),
            .req_o    (ch_req[c]),
            .we_o     (ch_we[c]),
            .res_o    (ch_res[c]),
            .addr_o   (ch_addr[c]),
            .wdata_o  (ch_wdata[c]),
            .src_o    (ch_src[c]),
            .done_o   (ch_done[c]),
            .isel_o   (ch_isel[c])
        );
    end

    for (genvar r = 0; r < NRES; r++) begin : g_res
        dma_rr_arb #(.N(NCH)) u_arb (
            .clk  (clk),
            .rst_n(rst_n),
            .req  (res_req[r]),
            .adv  (mem_gnt[r]),
            .win  (res_win[r])
        );
    end

    always_comb begin
        for (int r = 0; r < NRES; r++)
            for (int c = 0; c < NCH; c++)
                res_req[r][c] = ch_req[c] && (ch_res[c] == RW'(r));
    end

    always_comb begin
        for (int r = 0; r < NRES; r++) begin
            mem_req[r]   = |res_req[r];
            mem_we[r]    = 1'b0;
            mem_addr[r]  = '0;
            mem_wdata[r] = '0;
            for (int c = 0; c < NCH; c++) begin
                if (res_win[r][c]) begin
                    mem_we[r]    = ch_we[c];
                    mem_addr[r]  = ch_addr[c];
                    mem_wdata[r] = ch_wdata[c];
                end
            end
        end
        for (int c = 0; c < NCH; c++) begin
            ch_gnt[c] = 1'b0;
            for (int r = 0; r < NRES; r++)
                if (ch_res[c] == RW'(r)) ch_gnt[c] = res_win[r][c] && mem_gnt[r];
        end
        irq = '0;
        for (int c = 0; c < NCH; c++)
            for (int i = 0; i < NIRQ; i++)
                if (ch_done[c] && (ch_isel[c] == IW'(i))) irq[i] = 1'b1;
    end
endmodule

// File: rtl/dma_engine_chk.sv
module dma_engine_chk #(
    parameter int NCH  = 8,
    parameter int NRES = 2,
    parameter int AW   = 8,
    parameter int NIRQ = 6
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       cfg_we,
    input logic [NRES-1:0][NCH-1:0]   res_win,
    input logic [NCH-1:0]             ch_req,
    input logic [NCH-1:0]             ch_gnt,
    input logic [NCH-1:0][AW-1:0]     ch_addr,
    input logic [NRES-1:0]            mem_req,
    input logic [NRES-1:0]            mem_we,
    input logic [NRES-1:0]            mem_gnt,
    input logic [NIRQ-1:0]            irq
);
    for (genvar r = 0; r < NRES; r++) begin : g_r
        AST_ONE_WINNER: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(res_win[r])); // R4
    end

    for (genvar c = 0; c < NCH; c++) begin : g_c
        AST_HOLD_ON_STALL: assert property (@(posedge clk) disable iff (!rst_n)
            (ch_req[c] && !ch_gnt[c] && !cfg_we) |=> (ch_req[c] && $stable(ch_addr[c]))); // R8
        AST_GAP_AFTER_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
            ch_gnt[c] |=> !ch_req[c]); // R5
    end

    AST_IRQ_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (|irq) |-> $past(|(mem_req & mem_we & mem_gnt))); // R6
endmodule

bind dma_engine dma_engine_chk #(.NCH(NCH), .NRES(NRES), .AW(AW), .NIRQ(NIRQ)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .cfg_we (cfg_we),
    .res_win(res_win),
    .ch_req (ch_req),
    .ch_gnt (ch_gnt),
    .ch_addr(ch_addr),
    .mem_req(mem_req),
    .mem_we (mem_we),
    .mem_gnt(mem_gnt),
    .irq    (irq)
);

// File: tb/tb_dma_engine.sv
`timescale 1ns/1ps
module tb_dma_engine;
    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cfg_we = 1'b0;
    logic [2:0]       cfg_ch = '0;
    logic [2:0]       cfg_field = '0;
    logic [15:0]      cfg_wdata = '0;
    logic [1:0]       mem_req, mem_we;
    logic [1:0][7:0]  mem_addr;
    logic [1:0][15:0] mem_wdata;
    logic [1:0]       mem_gnt = 2'b11;
    logic [1:0][15:0] rd_q = '0;
    logic [5:0]       irq;

    always #2.5 clk = ~clk;

    dma_engine dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ch(cfg_ch),
        .cfg_field(cfg_field), .cfg_wdata(cfg_wdata), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_gnt(mem_gnt), .mem_rdata(rd_q), .irq(irq)
    );

    logic [15:0] mem [2][256];
    int rlog[2][64], rcyc[2][64], wlog[2][64], wcyc[2][64];
    int rcnt[2], wcnt[2];
    int irq_cnt[6];
    int irq_wide = 0, dual = 0, cyc = 0;
    logic [5:0] irq_prev = '0;
    int checks = 0, failures = 0;
    bit finished = 0;

    always @(posedge clk) begin
        cyc++;
        if (rst_n && (mem_req & mem_gnt) == 2'b11) dual++;
        for (int r = 0; r < 2; r++) begin
            if (rst_n && mem_req[r] && mem_gnt[r]) begin
                if (mem_we[r]) begin
                    mem[r][mem_addr[r]] = mem_wdata[r];
                    if (wcnt[r] < 64) begin wlog[r][wcnt[r]] = mem_addr[r]; wcyc[r][wcnt[r]] = cyc; end
                    wcnt[r]++;
                end else begin
                    rd_q[r] <= mem[r][mem_addr[r]];
                    if (rcnt[r] < 64) begin rlog[r][rcnt[r]] = mem_addr[r]; rcyc[r][rcnt[r]] = cyc; end
                    rcnt[r]++;
                end
            end
        end
        for (int i = 0; i < 6; i++) begin
            if (irq[i]) irq_cnt[i]++;
            if (irq[i] && irq_prev[i]) irq_wide++;
        end
        irq_prev <= irq;
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic clear_logs();
        @(negedge clk);
        for (int r = 0; r < 2; r++) begin rcnt[r] = 0; wcnt[r] = 0; end
        for (int i = 0; i < 6; i++) irq_cnt[i] = 0;
        irq_wide = 0;
        dual = 0;
    endtask

    task automatic cfg(input int ch, input int fld, input int val);
        @(negedge clk);
        cfg_we = 1'b1; cfg_ch = 3'(ch); cfg_field = 3'(fld); cfg_wdata = 16'(val);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    function automatic int ctl(input int run, input int circ, input int s, input int d, input int line);
        return run | (circ << 1) | (s << 2) | (d << 3) | (line << 4);
    endfunction

    task automatic setup(input int ch, input int sb, input int db, input int stp, input int len, input int per);
        cfg(ch, 0, sb); cfg(ch, 1, db); cfg(ch, 2, stp); cfg(ch, 3, len); cfg(ch, 4, per);
    endtask

    task automatic wait_writes(input int r, input int n, input string tag);
        int t = 0;
        while (wcnt[r] < n && t < 2000) begin @(negedge clk); t++; end
        chk({tag, " completion before timeout"}, int'(wcnt[r] >= n), 1);
    endtask

    task automatic wait_irq(input int line, input int n, input string tag);
        int t = 0;
        while (irq_cnt[line] < n && t < 2000) begin @(negedge clk); t++; end
        chk({tag, " irq before timeout"}, int'(irq_cnt[line] >= n), 1);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        chk("R9 mem_req in reset", mem_req, 0);
        chk("R9 irq in reset", irq, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R9 mem_req after reset", mem_req, 0);
        chk("R9 irq after reset", irq, 0);
    endtask

    task automatic t_linear();
        for (int k = 0; k < 16; k++) begin mem[0][8'h10 + k] = 16'hA000 + 16'(k); mem[1][8'h40 + k] = 16'hDEAD; end
        clear_logs();
        setup(0, 8'h10, 8'h40, 2, 5, 2);
        cfg(0, 5, ctl(1, 0, 0, 1, 1));
        wait_irq(1, 1, "R6 linear");
        repeat (40) @(negedge clk);
        chk("R2 linear read count", rcnt[0], 5);
        chk("R2 linear write count", wcnt[1], 5);
        for (int k = 0; k < 5; k++) begin
            chk("R2 linear read addr", rlog[0][k], 8'h10 + 2 * k);
            chk("R2 linear write addr", wlog[1][k], 8'h40 + 2 * k);
            chk("R8 linear data", mem[1][8'h40 + 2 * k], 16'hA000 + 2 * k);
        end
        chk("R2 word past end untouched", mem[1][8'h4A], 16'hDEAD);
        chk("R2 odd word untouched", mem[1][8'h41], 16'hDEAD);
        for (int k = 0; k < 4; k++) chk("R5 read spacing interval 2", rcyc[0][k + 1] - rcyc[0][k], 6);
        chk("R8 write two cycles after read", wcyc[1][0] - rcyc[0][0], 2);
        chk("R6 single pulse count", irq_cnt[1], 1);
        chk("R6 pulse width one", irq_wide, 0);
        chk("R6 pulse one cycle after last write", irq_cnt[0] + irq_cnt[2], 0);
    endtask

    task automatic t_circular();
        for (int k = 0; k < 8; k++) begin mem[0][8'h80 + k] = 16'hB000 + 16'(k); mem[1][8'hA0 + k] = 16'hDEAD; end
        clear_logs();
        setup(3, 8'h80, 8'hA0, 3, 4, 4);
        cfg(3, 5, ctl(1, 1, 0, 1, 2));
        wait_irq(2, 2, "R6 circular");
        cfg(3, 5, ctl(0, 1, 0, 1, 2));
        repeat (40) @(negedge clk);
        chk("R3 circular write count", wcnt[1], 8);
        chk("R1 stop by run bit", rcnt[0], 8);
        for (int k = 0; k < 8; k++) begin
            chk("R3 circular read addr", rlog[0][k], 8'h80 + (3 * k) % 4);
            chk("R3 circular write addr", wlog[1][k], 8'hA0 + (3 * k) % 4);
        end
        for (int k = 0; k < 4; k++) chk("R3 circular data", mem[1][8'hA0 + k], 16'hB000 + k);
        chk("R3 outside window untouched", mem[1][8'hA4], 16'hDEAD);
        chk("R5 read spacing interval 4", rcyc[0][1] - rcyc[0][0], 8);
        chk("R6 pulse every length transfers", irq_cnt[2], 2);
    endtask

    task automatic t_parallel();
        for (int k = 0; k < 4; k++) begin
            mem[0][k] = 16'hC000 + 16'(k); mem[1][k] = 16'hD000 + 16'(k);
            mem[0][8'h30 + k] = 16'h0; mem[1][8'h30 + k] = 16'h0;
        end
        setup(1, 8'h00, 8'h30, 1, 4, 0);
        setup(2, 8'h00, 8'h30, 1, 4, 0);
        clear_logs();
        cfg(1, 5, ctl(1, 0, 0, 0, 3));
        cfg(2, 5, ctl(1, 0, 1, 1, 4));
        wait_irq(3, 1, "R4 res0 copy");
        wait_irq(4, 1, "R4 res1 copy");
        repeat (5) @(negedge clk);
        chk("R4 both resources accepted in one cycle", int'(dual > 0), 1);
        for (int k = 0; k < 4; k++) begin
            chk("R4 res0 copy data", mem[0][8'h30 + k], 16'hC000 + k);
            chk("R4 res1 copy data", mem[1][8'h30 + k], 16'hD000 + k);
        end
    endtask

    task automatic t_round_robin();
        logic [7:0] held;
        int g0, g1, g2;
        for (int c = 0; c < 3; c++)
            for (int k = 0; k < 2; k++) begin
                mem[0][8'h50 + 16 * c + k] = 16'hE000 + 16'(16 * c + k);
                mem[1][8'h50 + 16 * c + k] = 16'h0;
            end
        for (int c = 0; c < 3; c++) setup(4 + c, 8'h50 + 16 * c, 8'h50 + 16 * c, 1, 2, 0);
        @(negedge clk); mem_gnt = 2'b10;
        clear_logs();
        for (int c = 0; c < 3; c++) cfg(4 + c, 5, ctl(1, 0, 0, 1, 5));
        repeat (2) @(negedge clk);
        chk("R8 request raised while stalled", mem_req[0], 1);
        held = mem_addr[0];
        repeat (4) @(negedge clk);
        chk("R8 request held while stalled", mem_req[0], 1);
        chk("R8 address held while stalled", mem_addr[0], held);
        chk("R8 nothing accepted while stalled", rcnt[0], 0);
        mem_gnt = 2'b11;
        wait_writes(1, 6, "R7 contention");
        repeat (5) @(negedge clk);
        g0 = rlog[0][0] >> 4; g1 = rlog[0][1] >> 4; g2 = rlog[0][2] >> 4;
        chk("R7 second grant follows first", g1, (g0 == 7) ? 5 : g0 + 1);
        chk("R7 third grant follows second", g2, (g1 == 7) ? 5 : g1 + 1);
        for (int c = 0; c < 3; c++)
            for (int k = 0; k < 2; k++)
                chk("R7 contended copy data", mem[1][8'h50 + 16 * c + k], 16'hE000 + 16 * c + k);
    endtask

    initial begin
        for (int r = 0; r < 2; r++) for (int a = 0; a < 256; a++) mem[r][a] = '0;
        t_reset();
        t_linear();
        t_circular();
        t_parallel();
        t_round_robin();
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog R1 actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule